// File: doc/BRIEF.md
# Software Write-Protection Sequence Guard

This block sits beside a byte-wide nonvolatile memory array and decides which byte loads on the write bus may reach the array. It filters the raw chip-enable, write-enable and output-enable strobes into clean byte-load events. It rejects strobes that are too short, strobes taken while output-enable is low, and anything during a low-supply condition. Each accepted load's address/data pair is then fed into a command-sequence decoder.

The decoder keeps one global protection flag, which is clear after reset. A three-load unlock prefix sets the flag and opens a page window. Loads that follow inside that window are passed to the array. A distinct six-load sequence clears the flag. While the flag is set, a load that is neither inside an open window nor the next step of a command sequence is refused. That load starts a lockout, and all loads are ignored until the lockout ends. The block reports a one-cycle write-permit pulse per permitted load, the protection state, and the lockout busy flag.

Top module: `swp_guard`

## Requirements
- R1: After reset, prot_on, write_permit and lock_busy are all low.
- R2: While protection is off, every accepted byte load produces a write_permit pulse of one cycle. The pulse follows the clock edge at which the strobe was released.
- R3: The prefix 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555 sets prot_on and opens a page window. Every load in that window is permitted. The window closes after PAGE_WIN cycles without a load.
- R4: While protection is on and no window is open, a load that is not the next expected command step is not permitted, and it starts a lockout.
- R5: lock_busy stays high for exactly LOCK_CYCLES cycles, starting from the cycle after the offending load. Byte loads made during that time are ignored entirely.
- R6: The six loads 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear prot_on. prot_on stays set until the last of them.
- R7: No byte load is accepted while output-enable is low, chip-enable is high, or supply_low is high.
- R8: A strobe is accepted only when chip-enable and write-enable have both been low for at least MIN_PW clock edges.
- R9: A load that does not match the next expected command step returns the detector to idle. A later partial sequence therefore cannot complete the earlier one.
- R10: While protection is on, the command loads themselves are not permitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| supply_low | input | 1 | Supply below write threshold, inhibits all loads |
| addr | input | AW | Byte-load address |
| data | input | DW | Byte-load data |
| write_permit | output | 1 | One-cycle pulse: the load just taken may be written |
| prot_on | output | 1 | Global protection flag |
| lock_busy | output | 1 | Lockout in progress, loads ignored |

## Verification
The bench builds the block with MIN_PW of 3, PAGE_WIN of 16 and LOCK_CYCLES of 40. At these values a strobe exactly one edge too short sits beside one of exactly minimum width. The page window can also be made to expire within a few dozen cycles, and a whole lockout can be counted edge by edge. The short lockout also lets two further lockouts be started: one from a broken sequence, and one from the tail of a prefix whose first load was swallowed during busy.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_C1,
        ST_C2,
        ST_D3,
        ST_D4,
        ST_D5,
        ST_OPEN
    } seq_st_e;
endpackage

// File: rtl/swp_strobe_filter.sv
module swp_strobe_filter #(
    parameter int MIN_PW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic supply_low,
    output logic load_evt
);
    localparam int CW = $clog2(MIN_PW + 1);

    typedef struct packed {
        logic [CW-1:0] width;
    } flt_s;

    flt_s cur_q, nxt_d;
    logic act;

    always_comb begin
        nxt_d = cur_q;
        act   = !ce_n && !we_n && oe_n && !supply_low;
        if (act) begin
            if (cur_q.width < CW'(MIN_PW))
                nxt_d.width = cur_q.width + 1'b1;
        end else begin
            nxt_d.width = '0;
        end
        load_evt = !act && oe_n && !supply_low && (cur_q.width >= CW'(MIN_PW));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_LOAD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |-> $past(!ce_n && !we_n)); // R8
endmodule

// File: rtl/swp_seq_decoder.sv
module swp_seq_decoder
    import swp_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter int          PAGE_WIN   = 100,
    parameter logic [AW-1:0] CMD_ADDR_A = 16'h5555,
    parameter logic [AW-1:0] CMD_ADDR_B = 16'h2AAA,
    parameter logic [DW-1:0] KEY_1      = 8'hAA,
    parameter logic [DW-1:0] KEY_2      = 8'h55,
    parameter logic [DW-1:0] KEY_ON     = 8'hA0,
    parameter logic [DW-1:0] KEY_OFF1   = 8'h80,
    parameter logic [DW-1:0] KEY_OFF2   = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_evt,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          permit,
    output logic          prot,
    output logic          lock_start
);
    localparam int WW = $clog2(PAGE_WIN + 1);

    typedef struct packed {
        seq_st_e       st;
        logic          prot;
        logic          permit;
        logic [WW-1:0] win;
    } dec_s;

    dec_s cur_q, nxt_d;
    logic hit;

    function automatic logic pair(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                  input logic [AW-1:0] ea, input logic [DW-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.permit = 1'b0;
        lock_start   = 1'b0;
        hit          = 1'b0;
        if (cur_q.st == ST_OPEN && !load_evt) begin
            if (cur_q.win == WW'(PAGE_WIN - 1)) begin
                nxt_d.st  = ST_IDLE;
                nxt_d.win = '0;
            end else begin
                nxt_d.win = cur_q.win + 1'b1;
            end
        end
        if (load_evt) begin
            case (cur_q.st)
                ST_IDLE: if (pair(addr, data, CMD_ADDR_A, KEY_1)) begin
                    hit = 1'b1; nxt_d.st = ST_C1;
                end
                ST_C1: if (pair(addr, data, CMD_ADDR_B, KEY_2)) begin
                    hit = 1'b1; nxt_d.st = ST_C2;
                end
                ST_C2: if (pair(addr, data, CMD_ADDR_A, KEY_ON)) begin
                    hit = 1'b1; nxt_d.st = ST_OPEN; nxt_d.prot = 1'b1; nxt_d.win = '0;
                end else if (pair(addr, data, CMD_ADDR_A, KEY_OFF1)) begin
                    hit = 1'b1; nxt_d.st = ST_D3;
                end
                ST_D3: if (pair(addr, data, CMD_ADDR_A, KEY_1)) begin
                    hit = 1'b1; nxt_d.st = ST_D4;
                end
                ST_D4: if (pair(addr, data, CMD_ADDR_B, KEY_2)) begin
                    hit = 1'b1; nxt_d.st = ST_D5;
                end
                ST_D5: if (pair(addr, data, CMD_ADDR_A, KEY_OFF2)) begin
                    hit = 1'b1; nxt_d.st = ST_IDLE; nxt_d.prot = 1'b0;
                end
                ST_OPEN: begin
                    hit = 1'b1; nxt_d.permit = 1'b1; nxt_d.win = '0;
                end
                default: nxt_d.st = ST_IDLE;
            endcase
            if (cur_q.st != ST_OPEN) begin
                nxt_d.permit = !cur_q.prot;
                if (!hit) begin
                    nxt_d.st   = ST_IDLE;
                    lock_start = cur_q.prot;
                end
            end
        end
        permit = cur_q.permit;
        prot   = cur_q.prot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, prot: 1'b0, permit: 1'b0, win: '0};
        else        cur_q <= nxt_d;
    end

    AST_PERMIT_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> $past(load_evt)); // R2
    AST_PROT_SET_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot) |-> cur_q.st == ST_OPEN); // R3
    AST_PROT_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot) |-> $past(cur_q.st) == ST_D5); // R6
endmodule

// File: rtl/swp_lockout_timer.sv
module swp_lockout_timer #(
    parameter int LOCK_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_s;

    tmr_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start)                nxt_d.cnt = TW'(LOCK_CYCLES);
        else if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - 1'b1;
        busy = (cur_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R5
endmodule

// File: rtl/swp_guard.sv
module swp_guard #(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int MIN_PW      = 3,
    parameter int PAGE_WIN    = 100,
    parameter int LOCK_CYCLES = 30000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          supply_low,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          write_permit,
    output logic          prot_on,
    output logic          lock_busy
);
    logic raw_evt;
    logic load_evt;
    logic lock_start;

    swp_strobe_filter #(.MIN_PW(MIN_PW)) u_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_low(supply_low), .load_evt(raw_evt)
    );

    assign load_evt = raw_evt && !lock_busy;

    swp_seq_decoder #(.AW(AW), .DW(DW), .PAGE_WIN(PAGE_WIN)) u_dec (
        .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .addr(addr), .data(data),
        .permit(write_permit), .prot(prot_on), .lock_start(lock_start)
    );

    swp_lockout_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .start(lock_start), .busy(lock_busy)
    );

    AST_BUSY_BLOCKS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy |-> !write_permit); // R5
    AST_INHIBIT_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_low) |-> !write_permit); // R7
endmodule

// File: tb/sim_swp_guard.sv
module sim_swp_guard;
    localparam int L  = 40;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        write_permit, prot_on, lock_busy;

    int n_run = 0;
    int n_fail = 0;

    typedef struct packed {
        logic permit;
        logic prot;
        logic busy;
    } exp_s;

    exp_s  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    swp_guard #(.MIN_PW(3), .PAGE_WIN(PW), .LOCK_CYCLES(L)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_low(supply_low), .addr(addr), .data(data),
        .write_permit(write_permit), .prot_on(prot_on), .lock_busy(lock_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: one byte load of w edges, expectation pushed to scoreboard
    task automatic load(input logic [15:0] a, input logic [7:0] d, input int w,
                        input logic ep, input logic eprot, input logic ebusy, input string tag);
        @(negedge clk);
        addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (w) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        exp_q.push_back('{permit: ep, prot: eprot, busy: ebusy});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compares at the edge where the release is registered
    initial begin
        forever begin
            exp_s  e;
            string t;
            wait (exp_q.size() > 0);
            @(posedge clk);
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " permit"}, int'(write_permit), int'(e.permit));
            check({t, " prot"},   int'(prot_on),      int'(e.prot));
            check({t, " busy"},   int'(lock_busy),    int'(e.busy));
        end
    end

    task automatic wait_idle();
        while (lock_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 prot", int'(prot_on), 0);
        check("R1 permit", int'(write_permit), 0);
        check("R1 busy", int'(lock_busy), 0);

        load(16'h0100, 8'h11, 4, 1, 0, 0, "R2 plain write");
        load(16'h0101, 8'h22, 2, 0, 0, 0, "R8 short strobe");
        load(16'h0102, 8'h22, 3, 1, 0, 0, "R8 minimum strobe");
        oe_n = 1'b0;
        load(16'h0103, 8'h33, 4, 0, 0, 0, "R7 oe low");
        oe_n = 1'b1;
        supply_low = 1'b1;
        load(16'h0104, 8'h44, 4, 0, 0, 0, "R7 supply low");
        supply_low = 1'b0;

        // broken prefix while unprotected, tail must not complete it
        load(16'h5555, 8'hAA, 4, 1, 0, 0, "R9 step1");
        load(16'h2AAA, 8'h00, 4, 1, 0, 0, "R9 mismatch");
        load(16'h2AAA, 8'h55, 4, 1, 0, 0, "R9 tail");
        load(16'h5555, 8'hA0, 4, 1, 0, 0, "R9 no enable");

        // enable prefix, page written in same window
        load(16'h5555, 8'hAA, 4, 1, 0, 0, "R3 p1");
        load(16'h2AAA, 8'h55, 4, 1, 0, 0, "R3 p2");
        load(16'h5555, 8'hA0, 4, 1, 1, 0, "R3 p3");
        load(16'h0300, 8'h5A, 4, 1, 1, 0, "R3 page byte0");
        load(16'h0301, 8'h5B, 4, 1, 1, 0, "R3 page byte1");
        repeat (PW + 4) @(negedge clk);

        load(16'h0302, 8'h5C, 4, 0, 1, 1, "R4 unprefixed");
        n = 0;
        while (lock_busy) begin n++; @(negedge clk); end
        check("R5 lockout length", n, L);
        repeat (3) @(negedge clk);

        load(16'h5555, 8'hAA, 4, 0, 1, 0, "R10 p1");
        load(16'h2AAA, 8'h55, 4, 0, 1, 0, "R10 p2");
        load(16'h5555, 8'hA0, 4, 0, 1, 0, "R10 p3");
        load(16'h0400, 8'h66, 4, 1, 1, 0, "R3 protected page");
        repeat (PW + 4) @(negedge clk);

        load(16'h5555, 8'hAA, 4, 0, 1, 0, "R9 prot step1");
        load(16'h1234, 8'h99, 4, 0, 1, 1, "R9 prot mismatch");
        load(16'h5555, 8'hAA, 4, 0, 1, 1, "R5 ignored in busy");
        wait_idle();
        load(16'h2AAA, 8'h55, 4, 0, 1, 1, "R5 ignored load not kept");
        wait_idle();

        load(16'h5555, 8'hAA, 4, 0, 1, 0, "R6 d1");
        load(16'h2AAA, 8'h55, 4, 0, 1, 0, "R6 d2");
        load(16'h5555, 8'h80, 4, 0, 1, 0, "R6 d3");
        load(16'h5555, 8'hAA, 4, 0, 1, 0, "R6 d4");
        load(16'h2AAA, 8'h55, 4, 0, 1, 0, "R6 d5");
        load(16'h5555, 8'h20, 4, 0, 0, 0, "R6 d6");
        load(16'h0500, 8'h77, 4, 1, 0, 0, "R6 write after disable");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule